// File: doc/BRIEF.md
# Filtered Energy Extraction with Bunch-Crossing Peak Selection

This block turns a stream of digitised calorimeter tower samples into one transverse-energy code per bunch crossing. Each accepted sample enters a five-deep history. A five-tap filter with signed, programmable weights combines that history. A programmable pedestal is then removed, with negative results clamped to zero. The result is shifted right by a programmable amount and limited to an 8-bit code. A peak selector compares each filtered code with its two neighbours in time. It passes the code only at a local maximum and emits zero at every other crossing, so a pulse that spreads over several samples is credited to a single crossing.

A sample at full ADC scale forces the overflow code at its own crossing. A final guard keeps the output stream from ever holding two non-zero codes in a row. The output code is meant to be copied unchanged to both a cluster-processing serialiser and a jet/energy serialiser. The pipeline moves only when the sample strobe is high, so the host clock may run faster than the crossing rate, for example twice as fast. Weights, pedestal and shift are static settings that change only while the block is held in reset.

Top module: `bcid_peak_filter`

## Requirements
- R1: While reset is low and on the first cycle after it, energyOut is 0 and energyValid is 0.
- R2: The filter sum for sample n is the sum over k = 0..4 of c[k]*s[n-k], where c[k] is the signed 4-bit value at coefSet[4k+3:4k], s is the 10-bit unsigned sample, and samples before the first one after reset count as 0.
- R3: The pedestal is subtracted from the filter sum, and a negative difference becomes 0.
- R4: The clamped difference is shifted right by shiftAmt (0..7), and any value above 255 becomes 255.
- R5: With e[n] the scaled code, crossing n yields e[n] when e[n-1] < e[n] and e[n] >= e[n+1], and 0 otherwise. e is 0 before the first sample.
- R6: If the previous published code is non-zero, the current code is 0, whatever the other rules say.
- R7: If rule R6 does not apply, a sample equal to 1023 yields 255 at its own crossing, whatever the peak rule says.
- R8: The code for sample n is published with energyValid high for exactly one cycle. This happens in the cycle after the clock edge that accepts sample n+2. The first two accepted samples after reset publish nothing.
- R9: Cycles with sampleValid low are ignored: no pipeline stage advances, energyValid is 0, and energyOut holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe marking a new crossing sample |
| sampleIn | input | 10 | Unsigned ADC sample |
| coefSet | input | 20 | Five signed 4-bit weights; weight k in bits 4k+3:4k applies to the sample k crossings old |
| pedestal | input | 12 | Unsigned offset removed from the filter sum |
| shiftAmt | input | 3 | Right-shift applied before limiting |
| energyOut | output | 8 | Energy code for the crossing; 255 marks overflow |
| energyValid | output | 1 | One-cycle pulse when energyOut takes a new crossing's code |

## Verification
The overflow forcing and the adjacency guard both act on a crossing's code in the same cycle. The same is true of the forcing and a genuine peak. The bench provokes these collisions with runs of full-scale samples placed next to each other and next to a rising pulse. Forcing should then alternate 255 and 0 rather than emit consecutive overflows. A behavioural reference, kept as a list of past samples and the last published code, predicts every cycle, so the winner of each collision is judged crossing by crossing. Gaps in the strobe are mixed into the same runs, so the hold rule is also exercised while those collisions are pending.

// File: rtl/bcid_pkg.sv
package bcid_pkg;
  // strobes issued by the control half to the datapath half
  typedef struct packed {
    logic shiftEn;   // accept a sample, advance history and code stages
    logic decideEn;  // publish the verdict for the centre crossing
  } bcidStrobe_t;
endpackage

// File: rtl/bcid_control.sv
module bcid_control
  import bcid_pkg::*;
#(
  parameter int LEAD = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  output bcidStrobe_t strobe,
  output logic        energyValid
);
  localparam int CNT_W = $clog2(LEAD + 1);

  logic [CNT_W-1:0] warmCnt;
  logic             warm;

  assign warm            = (warmCnt == CNT_W'(LEAD));
  assign strobe.shiftEn  = sampleValid;
  assign strobe.decideEn = sampleValid && warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt     <= '0;
      energyValid <= 1'b0;
    end else begin
      if (sampleValid && !warm) warmCnt <= warmCnt + 1'b1;
      energyValid <= strobe.decideEn;
    end
  end
endmodule

// File: rtl/bcid_datapath.sv
module bcid_datapath
  import bcid_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 4,
  parameter int TAPS     = 5,
  parameter int PED_W    = 12,
  parameter int SHIFT_W  = 3,
  parameter int OUT_W    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bcidStrobe_t              strobe,
  input  logic [SAMPLE_W-1:0]      sampleIn,
  input  logic [TAPS*COEF_W-1:0]   coefSet,
  input  logic [PED_W-1:0]         pedestal,
  input  logic [SHIFT_W-1:0]       shiftAmt,
  output logic [OUT_W-1:0]         energyOut
);
  localparam int PROD_W = SAMPLE_W + 1 + COEF_W;
  localparam int SUM_W  = PROD_W + $clog2(TAPS);
  localparam int DIFF_W = SUM_W + 1;
  localparam int POS_W  = DIFF_W - 1;

  logic [SAMPLE_W-1:0]      hist [TAPS];
  logic signed [PROD_W-1:0] prod [TAPS];
  logic signed [SUM_W-1:0]  firSum;
  logic signed [DIFF_W-1:0] pedExt, diff;
  logic [POS_W-1:0]         posVal, scaled;
  logic [OUT_W-1:0]         eNow, eReg0, eReg1, verdict;
  logic                     isPeak, satMid;

  // sample history: hist[k] is the sample k crossings old
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
    end else if (strobe.shiftEn) begin
      hist[0] <= sampleIn;
      for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
    end
  end

  // weighted taps
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic signed [SAMPLE_W:0] sampExt;
    logic signed [COEF_W-1:0] weight;
    assign sampExt = {1'b0, hist[k]};
    assign weight  = coefSet[k*COEF_W +: COEF_W];
    assign prod[k] = sampExt * weight;
  end

  always_comb begin
    firSum = '0;
    for (int k = 0; k < TAPS; k++) firSum = firSum + SUM_W'(prod[k]);
  end

  // pedestal removal, clamp, scale, limit
  assign pedExt = DIFF_W'({1'b0, pedestal});
  assign diff   = DIFF_W'(firSum) - pedExt;
  assign posVal = diff[DIFF_W-1] ? '0 : diff[POS_W-1:0];
  assign scaled = posVal >> shiftAmt;
  assign eNow   = (|scaled[POS_W-1:OUT_W]) ? {OUT_W{1'b1}} : scaled[OUT_W-1:0];

  // code stages: eReg0 is the centre crossing, eReg1 the one before it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eReg0 <= '0;
      eReg1 <= '0;
    end else if (strobe.shiftEn) begin
      eReg0 <= eNow;
      eReg1 <= eReg0;
    end
  end

  assign isPeak = (eReg1 < eReg0) && (eReg0 >= eNow);
  assign satMid = (hist[1] == {SAMPLE_W{1'b1}});

  always_comb begin
    if (energyOut != '0)  verdict = '0;
    else if (satMid)      verdict = {OUT_W{1'b1}};
    else if (isPeak)      verdict = eReg0;
    else                  verdict = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                energyOut <= '0;
    else if (strobe.decideEn) energyOut <= verdict;
  end
endmodule

// File: rtl/bcid_peak_filter.sv
module bcid_peak_filter
  import bcid_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 4,
  parameter int TAPS     = 5,
  parameter int PED_W    = 12,
  parameter int SHIFT_W  = 3,
  parameter int OUT_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic [SAMPLE_W-1:0]    sampleIn,
  input  logic [TAPS*COEF_W-1:0] coefSet,
  input  logic [PED_W-1:0]       pedestal,
  input  logic [SHIFT_W-1:0]     shiftAmt,
  output logic [OUT_W-1:0]       energyOut,
  output logic                   energyValid
);
  bcidStrobe_t strobe;

  bcid_control #(.LEAD(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .strobe(strobe), .energyValid(energyValid)
  );

  bcid_datapath #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS),
    .PED_W(PED_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .coefSet(coefSet), .pedestal(pedestal), .shiftAmt(shiftAmt),
    .energyOut(energyOut)
  );
endmodule

// File: rtl/bcid_peak_filter_chk.sv
module bcid_peak_filter_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             energyValid,
  input logic [OUT_W-1:0] energyOut
);
  logic       lastHit;
  logic [1:0] accCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastHit <= 1'b0;
      accCnt  <= '0;
    end else begin
      if (energyValid) lastHit <= (energyOut != '0);
      if (sampleValid && accCnt != 2'd3) accCnt <= accCnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rstN) |-> (energyOut == '0 && !energyValid));

  // R6
  no_adjacent_hits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (energyValid && lastHit) |-> (energyOut == '0));

  // R8
  pulse_after_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    energyValid |-> $past(sampleValid));

  // R8
  warmup_chk: assert property (@(posedge clk) disable iff (!rstN)
    energyValid |-> (accCnt == 2'd3));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !energyValid |-> $stable(energyOut));
endmodule

bind bcid_peak_filter bcid_peak_filter_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .energyValid(energyValid), .energyOut(energyOut)
);

// File: tb/sim_bcid_peak_filter.sv
`timescale 1ns/1ps
module sim_bcid_peak_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [9:0]  sampleIn = '0;
  logic [19:0] coefSet = '0;
  logic [11:0] pedestal = '0;
  logic [2:0]  shiftAmt = '0;
  logic [7:0]  energyOut;
  logic        energyValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  int smp[$];
  int prevOut = 0;
  int expOut = 0;
  bit expValid = 0;

  always #10 clk = ~clk;

  bcid_peak_filter u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .coefSet(coefSet), .pedestal(pedestal), .shiftAmt(shiftAmt),
    .energyOut(energyOut), .energyValid(energyValid)
  );

  function automatic logic [19:0] packCoef(int a, int b, int c, int d, int e);
    return {4'(e), 4'(d), 4'(c), 4'(b), 4'(a)};
  endfunction

  // R2 R3 R4 reference code for crossing n
  function automatic int energyOf(int n);
    int acc = 0;
    if (n < 0) return 0;
    for (int k = 0; k < 5; k++) begin
      int idx = n - k;
      int w = $signed(coefSet[4*k +: 4]);
      if (idx >= 0 && idx < smp.size()) acc += w * smp[idx];
    end
    acc -= int'(pedestal);
    if (acc < 0) acc = 0;
    acc = acc >>> shiftAmt;
    if (acc > 255) acc = 255;
    return acc;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // compare last edge's result, then drive the next input and advance the model
  task automatic tick(bit v, int d);
    @(negedge clk);
    check(tag, energyValid, expValid, "energyValid");
    check(tag, energyOut, expOut, "energyOut");
    sampleValid = v;
    sampleIn = 10'(d);
    expValid = 0;
    if (v) begin
      smp.push_back(d);
      if (smp.size() >= 3) begin
        int m = smp.size() - 3;
        int em = energyOf(m);
        int val;
        if (prevOut != 0) val = 0;                      // R6
        else if (smp[m] == 1023) val = 255;             // R7
        else if (energyOf(m-1) < em && em >= energyOf(m+1)) val = em; // R5
        else val = 0;
        expOut = val;
        prevOut = val;
        expValid = 1;                                   // R8
      end
    end
  endtask

  task automatic doReset(logic [19:0] cf, int ped, int sh);
    @(negedge clk);
    rstN = 0;
    sampleValid = 0;
    sampleIn = '0;
    coefSet = cf;
    pedestal = 12'(ped);
    shiftAmt = 3'(sh);
    smp.delete();
    prevOut = 0;
    expOut = 0;
    expValid = 0;
    repeat (2) @(negedge clk);
    check("R1", energyOut, 0, "energyOut in reset");
    check("R1", energyValid, 0, "energyValid in reset");
    rstN = 1;
  endtask

  task automatic runList(int vals[$], bit gaps);
    foreach (vals[i]) begin
      tick(1, vals[i]);
      if (gaps && (i % 2 == 1)) tick(0, 777);           // R9 ignored data
    end
    repeat (3) tick(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset and first cycle after
    tag = "R1";
    doReset(packCoef(1, 2, 3, 2, 1), 0, 0);
    tick(0, 0);

    // R2 R5 R8: single pulse, weights on distinct ages
    tag = "R2/R5/R8";
    doReset(packCoef(1, 2, -1, 0, 3), 0, 0);
    runList('{0, 0, 10, 40, 20, 5, 0, 0, 0, 0, 0}, 0);

    // R9: same pulse with idle cycles carrying junk data
    tag = "R9";
    doReset(packCoef(2, 1, 0, 1, 0), 0, 1);
    runList('{0, 3, 60, 90, 30, 8, 0, 0, 0}, 1);

    // R3: pedestal above baseline, negative weight
    tag = "R3";
    doReset(packCoef(3, -1, 2, 0, 1), 100, 0);
    runList('{30, 30, 30, 50, 120, 70, 30, 30, 30, 30, 30}, 0);

    // R4: large pulse, shift and limit
    tag = "R4";
    doReset(packCoef(7, 7, 7, 7, 7), 0, 2);
    runList('{0, 100, 900, 1000, 600, 10, 0, 0, 0}, 0);
    doReset(packCoef(1, 0, 0, 0, 0), 0, 7);
    runList('{0, 300, 1000, 200, 0, 0}, 0);

    // R5 R6: plateaus and close twin peaks
    tag = "R5/R6";
    doReset(packCoef(1, 0, 0, 0, 0), 0, 0);
    runList('{0, 50, 50, 50, 20, 80, 10, 90, 30, 60, 60, 70, 0, 0}, 0);

    // R7 R6: saturated runs meeting each other and a peak
    tag = "R7/R6";
    doReset(packCoef(1, 0, 0, 0, 0), 0, 2);
    runList('{0, 0, 1023, 1023, 1023, 500, 0, 200, 1023, 100, 0, 0}, 0);
    doReset(packCoef(1, 1, 0, 0, 0), 0, 3);
    runList('{0, 400, 800, 1023, 0, 0, 0, 1023, 1023, 0, 0}, 1);

    // R2-mixed stress with random gaps and values
    tag = "R9/R5/R7";
    doReset(packCoef(1, 3, 5, 3, -1), 20, 3);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      int d = (r < 4) ? 1023 : int'($urandom_range(0, 1022));
      tick(r < 70, d);
    end
    repeat (3) tick(0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule